// File: doc/BRIEF.md
# LED Blink Controller

This block drives a single LED output with a programmable on/off pattern. A prescaler divides the system clock by a power of two, which is chosen by a time-base selector. Each prescaler tick advances a phase counter that wraps at a programmed period length. The LED is lit while the phase is below a programmed duty value, so software sets both the blink rate and the on-fraction.

An optional auto-stop mode counts completed periods and ends blinking after a programmed number of them. At that point the run bit clears, the LED goes dark and a sticky done flag is set. The done flag drives an interrupt output, and a mask bit can hide that output.

Software reaches the block through a minimal write-strobe register bus with four word-aligned registers. Reads are combinational on the address.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset every register reads 0, `led_o` is 0 and `irq_o` is 0.
- R2: Registers decode on `bus_addr[3:2]` and only when `bus_addr[1:0]` is 0; other writes are ignored. Index 0 is control, 1 is period (12 bits), 2 is duty (12 bits) and 3 is the stop count (16 bits). Unused upper bits read 0. The control layout is: select in [3:0], run in bit 4, auto-stop in bit 5, interrupt mask in bit 6, and done flag in bit 7 (read value).
- R3: While run is set, the phase advances once every 2^(13−s) clocks, where s is the select value. One blink cycle lasts max(period,1)·2^(13−s) clocks.
- R4: A select value above 13 acts exactly like 13.
- R5: With 0 < duty < period, the LED is lit for duty ticks out of every period ticks.
- R6: With duty ≥ period and duty ≠ 0, the LED stays lit continuously while running.
- R7: With duty = 0 the LED never lights.
- R8: Clearing run makes `led_o` 0 one clock after the write edge and resets the phase. After re-enabling, the first lit stretch is a full duty length.
- R9: With auto-stop set, each wrap of the phase decrements the stop count. The wrap that finds a count of 1 or less clears run, sets the done flag and leaves the count at 0. With period 4, count 3 and select 13, this happens 12 clocks after the enabling write edge.
- R10: `irq_o` is high exactly while the done flag is set and the mask bit is 0. A masked flag stays readable in control bit 7.
- R11: Writing control with bit 7 = 1 clears the done flag. Writing bit 7 = 0 leaves it unchanged.
- R12: With auto-stop clear, the stop count is never decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, combinational on `bus_addr` |
| led_o | output | 1 | LED drive |
| irq_o | output | 1 | Auto-stop interrupt, level |

## Verification
A write lands on the clock edge that follows the strobe. `bus_rdata` and `irq_o` follow the registers in the same cycle. `led_o` is registered, so it reflects the phase one clock later, and it drops one clock after the edge that clears run.

The bench drives all inputs on falling edges and samples only on falling edges. It therefore counts the exact number of clocks from a write edge to each result; for the auto-stop case, the flag must first appear at the twelfth falling edge. Duty ratios are measured as lit-sample counts over four whole blink cycles, after a settling gap. That makes the count independent of the phase at which the window opens.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
   localparam int unsigned SEL_W  = 4;
   localparam int unsigned CTRL_W = SEL_W + 4;

   localparam logic [1:0] IDX_CTRL = 2'd0;
   localparam logic [1:0] IDX_PER  = 2'd1;
   localparam logic [1:0] IDX_DUTY = 2'd2;
   localparam logic [1:0] IDX_STOP = 2'd3;

   typedef struct packed {
      logic             flag;
      logic             irq_mask;
      logic             auto_stop;
      logic             run;
      logic [SEL_W-1:0] sel;
   } ctrl_t;
endpackage

// File: rtl/led_tb_prescaler.sv
module led_tb_prescaler #(
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned TB_MAX = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   if (TB_MAX > (2**SEL_W) - 1) begin : g_bad_max
      $error("TB_MAX does not fit the selector width");
   end

   if (TB_MAX == 0) begin : g_no_div
      assign tick = run;
   end else begin : g_div
      logic [TB_MAX-1:0] cnt_q;
      logic [SEL_W-1:0]  sel_c;
      logic [SEL_W-1:0]  shift;
      logic [TB_MAX-1:0] mask;

      // clamp out-of-range selectors to the fastest legal base
      assign sel_c = (32'(sel) > TB_MAX) ? SEL_W'(TB_MAX) : sel;
      assign shift = SEL_W'(TB_MAX) - sel_c;
      assign mask  = ~({TB_MAX{1'b1}} << shift);
      assign tick  = run && ((cnt_q & mask) == mask);

      always_ff @(posedge clk) begin
         if (!rst_n || !run) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/led_phase_gen.sv
module led_phase_gen #(
   parameter int unsigned PER_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   input  logic [PER_W-1:0] duty,
   output logic             wrap,
   output logic [PER_W-1:0] phase,
   output logic             led
);
   logic [PER_W-1:0] phase_q;
   logic [PER_W:0]   nxt;
   logic             lit;

   assign nxt   = {1'b0, phase_q} + 1'b1;
   assign wrap  = tick && (nxt >= {1'b0, period});
   assign phase = phase_q;
   assign lit   = (duty != '0) && ((duty >= period) || (phase_q < duty));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) phase_q <= '0;
      else if (tick)      phase_q <= wrap ? '0 : nxt[PER_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) led <= 1'b0;
      else        led <= run && lit;
   end
endmodule

// File: rtl/led_autostop.sv
module led_autostop #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             armed,
   input  logic             wrap,
   output logic [CNT_W-1:0] count,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   assign done  = armed && wrap && (cnt_q <= CNT_W'(1));
   assign count = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (armed && wrap)  cnt_q <= done ? '0 : cnt_q - 1'b1;
   end
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
   import led_blink_pkg::*;
#(
   parameter int unsigned TB_MAX = 13,
   parameter int unsigned PER_W  = 12,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              led_o,
   output logic              irq_o
);
   localparam int unsigned B_RUN  = SEL_W;
   localparam int unsigned B_AUTO = SEL_W + 1;
   localparam int unsigned B_MASK = SEL_W + 2;
   localparam int unsigned B_FLAG = SEL_W + 3;

   if (DATA_W < CNT_W || DATA_W < PER_W || DATA_W < CTRL_W) begin : g_bad_data
      $error("DATA_W narrower than a register");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover four word registers");
   end

   logic       hi_zero;
   if (ADDR_W > 4) begin : g_addr_hi
      assign hi_zero = (bus_addr[ADDR_W-1:4] == '0);
   end else begin : g_addr_exact
      assign hi_zero = 1'b1;
   end

   logic [1:0] idx;
   logic       wr_ok;
   assign idx   = bus_addr[3:2];
   assign wr_ok = bus_wr && hi_zero && (bus_addr[1:0] == 2'b00);

   logic wr_ctrl, wr_per, wr_duty, wr_stop;
   assign wr_ctrl = wr_ok && (idx == IDX_CTRL);
   assign wr_per  = wr_ok && (idx == IDX_PER);
   assign wr_duty = wr_ok && (idx == IDX_DUTY);
   assign wr_stop = wr_ok && (idx == IDX_STOP);

   ctrl_t            ctrl_q;
   logic [PER_W-1:0] period_q;
   logic [PER_W-1:0] duty_q;
   logic             run_w;
   logic             flag_w;
   logic             tick_w;
   logic             wrap_w;
   logic             done_w;
   logic [PER_W-1:0] phase_w;
   logic [CNT_W-1:0] stop_cnt;

   assign run_w  = ctrl_q.run;
   assign flag_w = ctrl_q.flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.sel       <= bus_wdata[SEL_W-1:0];
            ctrl_q.run       <= bus_wdata[B_RUN];
            ctrl_q.auto_stop <= bus_wdata[B_AUTO];
            ctrl_q.irq_mask  <= bus_wdata[B_MASK];
         end else if (done_w) begin
            ctrl_q.run <= 1'b0;
         end
         ctrl_q.flag <= (ctrl_q.flag && !(wr_ctrl && bus_wdata[B_FLAG])) || done_w;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         duty_q   <= '0;
      end else begin
         if (wr_per)  period_q <= bus_wdata[PER_W-1:0];
         if (wr_duty) duty_q   <= bus_wdata[PER_W-1:0];
      end
   end

   led_tb_prescaler #(.SEL_W(SEL_W), .TB_MAX(TB_MAX)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_w),
      .sel   (ctrl_q.sel),
      .tick  (tick_w)
   );

   led_phase_gen #(.PER_W(PER_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_w),
      .tick   (tick_w),
      .period (period_q),
      .duty   (duty_q),
      .wrap   (wrap_w),
      .phase  (phase_w),
      .led    (led_o)
   );

   led_autostop #(.CNT_W(CNT_W)) u_stop (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_stop),
      .load_val (bus_wdata[CNT_W-1:0]),
      .armed    (run_w && ctrl_q.auto_stop),
      .wrap     (wrap_w),
      .count    (stop_cnt),
      .done     (done_w)
   );

   assign irq_o = flag_w && !ctrl_q.irq_mask;

   always_comb begin
      case (idx)
         IDX_CTRL: bus_rdata = DATA_W'(ctrl_q);
         IDX_PER:  bus_rdata = DATA_W'(period_q);
         IDX_DUTY: bus_rdata = DATA_W'(duty_q);
         default:  bus_rdata = DATA_W'(stop_cnt);
      endcase
   end
endmodule

// File: rtl/led_blink_chk.sv
module led_blink_chk #(
   parameter int unsigned PER_W = 12,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             run,
   input logic             flag,
   input logic             done,
   input logic [PER_W-1:0] period,
   input logic [PER_W-1:0] duty,
   input logic [PER_W-1:0] phase,
   input logic [CNT_W-1:0] stop_cnt,
   input logic             led_o
);
   // R8: once run is low the LED is dark on the following clock
   a_r8_dark_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !led_o);

   // R7: a zero duty never produces light
   a_r7_zero_duty_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |=> !led_o);

   // R6: duty at or above period keeps the LED lit
   a_r6_solid_on: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && ($past(duty) != '0) && ($past(duty) >= $past(period))) |-> led_o);

   // R3: the phase stays inside the period while the period is unchanged
   a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (period != '0) && (phase < period) && !bus_wr) |=> (phase < period));

   // R9: the final wrap halts the block, sets the flag and empties the count
   a_r9_stop_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !bus_wr) |=> (!run && flag && (stop_cnt == '0)));
endmodule

bind led_blink_ctrl led_blink_chk #(.PER_W(PER_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .run      (run_w),
   .flag     (flag_w),
   .done     (done_w),
   .period   (period_q),
   .duty     (duty_q),
   .phase    (phase_w),
   .stop_cnt (stop_cnt),
   .led_o    (led_o)
);

// File: tb/led_blink_ctrl_tb.sv
module led_blink_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr;
   logic [3:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic        led_o;
   logic        irq_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   led_blink_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .led_o     (led_o),
      .irq_o     (irq_o)
   );

   // {select, period, duty}
   localparam int NV = 8;
   localparam logic [27:0] VEC [NV] = '{
      {4'd13, 12'd8, 12'd3},
      {4'd13, 12'd5, 12'd5},
      {4'd13, 12'd6, 12'd0},
      {4'd12, 12'd4, 12'd1},
      {4'd15, 12'd7, 12'd2},
      {4'd13, 12'd3, 12'd9},
      {4'd11, 12'd5, 12'd2},
      {4'd13, 12'd0, 12'd4}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] rv;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(4'(a * 4), rv);
         chk(rv == 16'h0, "R1 reg", rv, 0);
      end
      chk(led_o == 1'b0, "R1 led", led_o, 0);
      chk(irq_o == 1'b0, "R1 irq", irq_o, 0);

      // R2 register map and width
      wr(4'h0, 16'hFF6B); rd(4'h0, rv); chk(rv == 16'h006B, "R2 ctrl", rv, 16'h6B);
      wr(4'h4, 16'hFFFF); rd(4'h4, rv); chk(rv == 16'h0FFF, "R2 period", rv, 16'hFFF);
      wr(4'h8, 16'h1234); rd(4'h8, rv); chk(rv == 16'h0234, "R2 duty", rv, 16'h234);
      wr(4'hC, 16'hBEEF); rd(4'hC, rv); chk(rv == 16'hBEEF, "R2 stop", rv, 16'hBEEF);
      wr(4'h6, 16'h0001); rd(4'h4, rv); chk(rv == 16'h0FFF, "R2 unaligned ignored", rv, 16'hFFF);
      wr(4'h0, 16'h0000);

      // table walk: duty ratio, time base, clamp
      for (int i = 0; i < NV; i++) begin
         int sel, per, dty, cpt, plen, hi, expv;
         string tag;
         sel = int'(VEC[i][27:24]); per = int'(VEC[i][23:12]); dty = int'(VEC[i][11:0]);
         wr(4'h0, 16'h0000);
         wr(4'h4, 16'(per));
         wr(4'h8, 16'(dty));
         wr(4'h0, 16'h0010 | 16'(sel));
         cpt  = 1 << (13 - ((sel > 13) ? 13 : sel));
         plen = ((per == 0) ? 1 : per) * cpt;
         repeat (2 * plen) @(negedge clk);
         hi = 0;
         for (int c = 0; c < 4 * plen; c++) begin
            @(negedge clk);
            if (led_o) hi++;
         end
         if (dty == 0)        begin expv = 0;            tag = "R7 dark";  end
         else if (dty >= per) begin expv = 4 * plen;     tag = "R6 solid"; end
         else if (sel > 13)   begin expv = 4 * dty * cpt; tag = "R4 clamp"; end
         else                 begin expv = 4 * dty * cpt; tag = "R5 R3 ratio"; end
         chk(hi == expv, tag, hi, expv);
      end

      // R8 disable timing and phase restart
      wr(4'h0, 16'h0000); wr(4'h4, 16'd4); wr(4'h8, 16'd9); wr(4'h0, 16'h001D);
      repeat (3) @(negedge clk);
      chk(led_o == 1'b1, "R8 lit before stop", led_o, 1);
      wr(4'h0, 16'h000D);
      @(negedge clk);
      chk(led_o == 1'b0, "R8 dark next clock", led_o, 0);
      wr(4'h4, 16'd10); wr(4'h8, 16'd3); wr(4'h0, 16'h001D);
      begin
         int hi = 0; bit first = 1'b0;
         for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (c == 0) first = led_o;
            if (led_o) hi++;
         end
         chk(first == 1'b1, "R8 restart lit", first, 1);
         chk(hi == 3, "R8 restart duty", hi, 3);
      end

      // R12 count untouched without auto-stop
      wr(4'h0, 16'h0000); wr(4'h4, 16'd3); wr(4'hC, 16'd5); wr(4'h0, 16'h001D);
      repeat (30) @(negedge clk);
      rd(4'hC, rv); chk(rv == 16'd5, "R12 count kept", rv, 5);

      // R9 auto-stop timing and end state
      wr(4'h0, 16'h0000); wr(4'h4, 16'd4); wr(4'h8, 16'd2); wr(4'hC, 16'd3);
      wr(4'h0, 16'h003D);
      begin
         int k = 0;
         while (!irq_o && k < 40) begin
            @(negedge clk);
            k++;
         end
         chk(k == 12, "R9 stop cycle", k, 12);
      end
      @(negedge clk);
      chk(led_o == 1'b0, "R9 led dark", led_o, 0);
      rd(4'h0, rv); chk(rv == 16'h00AD, "R9 ctrl after stop", rv, 16'hAD);
      rd(4'hC, rv); chk(rv == 16'h0000, "R9 count zero", rv, 0);

      // R11 flag clearing
      wr(4'h0, 16'h002D); rd(4'h0, rv); chk(rv == 16'h00AD, "R11 flag kept", rv, 16'hAD);
      wr(4'h0, 16'h0080); rd(4'h0, rv); chk(rv == 16'h0000, "R11 flag cleared", rv, 0);
      chk(irq_o == 1'b0, "R11 irq low", irq_o, 0);

      // R10 masking
      wr(4'h4, 16'd2); wr(4'hC, 16'd1); wr(4'h0, 16'h007D);
      repeat (20) @(negedge clk);
      chk(irq_o == 1'b0, "R10 masked irq", irq_o, 0);
      rd(4'h0, rv); chk(rv == 16'h00ED, "R10 flag visible", rv, 16'hED);
      wr(4'h0, 16'h002D);
      chk(irq_o == 1'b1, "R10 unmasked irq", irq_o, 1);
      wr(4'h0, 16'h0080);
      chk(irq_o == 1'b0, "R10 irq after clear", irq_o, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule